// File: doc/BRIEF.md
# Time-Update Interrupt and Flag Controller

This block turns calendar strobes into periodic update events and gathers three kinds of event (update, fixed-cycle timer and alarm) into sticky flags. Each flag has an enable. When an event arrives and its enable is set, the block pulls a shared active-low, open-drain interrupt line. The line is modelled here as an output-enable signal, `int_oe`. The update source follows either the second strobe or the minute strobe, and a control bit picks which.

Update and timer requests release the line by themselves after a fixed hold window. The default window is 256 cycles of the 32.768 kHz timekeeping clock, about 7.8 ms. An alarm request keeps the line asserted until software clears the alarm flag or clears the alarm enable. Flags clear only when software writes 0 to them. A low-voltage flag is set by reset and by a detector input, and it follows the same clear-only rule. Software reaches the flag register and the control register through a simple register port. Writes take effect on the clock edge, and reads are combinational.

Register layout. The flag register is at address 0xE: bit 5 is the update flag, bit 4 the timer flag, bit 3 the alarm flag and bit 1 the low-voltage flag. The control register is at address 0xF: bits 7:6 hold the compensation-interval code, which is stored only. Bit 5 is the update enable, bit 4 the timer enable, bit 3 the alarm enable, and bit 0 selects the update unit (0 means seconds, 1 means minutes). All other bits, and every other address, read as 0.

Top module: `tu_irq_ctrl`

## Requirements
- R1: After reset the flag register reads 0x02 (only the low-voltage flag set), the control register reads 0x00, and `int_oe` is 0.
- R2: With control bit 0 at 0, `sec_tick` sets the update flag (flag bit 5) and `min_tick` has no effect. With control bit 0 at 1, `min_tick` sets it and `sec_tick` has no effect.
- R3: An update event with the update enable (control bit 5) at 1 drives `int_oe` high for exactly HOLD_CYCLES cycles, starting the cycle after the event. The line is then released while the update flag stays set.
- R4: With the update enable at 0, an update event sets the update flag but never drives `int_oe`.
- R5: Writing 0 to the update enable while its request is active releases `int_oe` from the next cycle. The update flag is kept.
- R6: `timer_evt` sets the timer flag (flag bit 4). With the timer enable (control bit 4) at 1, it drives the same HOLD_CYCLES window. Writing 0 to the timer enable cancels that window at once.
- R7: `alarm_evt` sets the alarm flag (flag bit 3). While both the alarm flag and the alarm enable (control bit 3) are 1, `int_oe` stays high with no time limit. Clearing either one releases it the next cycle.
- R8: Writing 1 to a flag bit leaves it unchanged, and writing 0 clears it. This applies to the update, timer, alarm and low-voltage (flag bit 1) flags.
- R9: If an event and a write of 0 to its flag fall in the same cycle, the event wins and the flag ends set.
- R10: The control register reads back bits 7:3 and bit 0 as written, with bits 2:1 reading 0. Any address other than 0xE and 0xF reads 0x00.
- R11: A new update event during an active window restarts it, so `int_oe` stays high for HOLD_CYCLES cycles after the last event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timekeeping clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe at each second boundary |
| min_tick | input | 1 | One-cycle strobe at each minute boundary |
| timer_evt | input | 1 | One-cycle strobe from the fixed-cycle timer |
| alarm_evt | input | 1 | One-cycle strobe from the alarm comparator |
| lowv_det | input | 1 | Low-voltage detector strobe, sets the low-voltage flag |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from the address |
| int_oe | output | 1 | Pull-down enable for the open-drain interrupt line |

## Verification
The cases hardest to reach from the ports are the two same-cycle collisions. One is an event landing in the very cycle that software writes 0 to its flag. The other is an enable being cleared in the middle of a hold window, and a retrigger arriving in that window. The bench reaches these by driving the event strobe and the register write together on one falling edge, and by counting exact cycles from the event before it issues the cancel or the second strobe. It then counts how many sampled cycles `int_oe` is high, so an off-by-one window length or a restart that does not reload the counter shows up as a wrong count.

// File: rtl/tu_pkg.sv
package tu_pkg;
    localparam logic [3:0] FLAG_ADDR = 4'hE;
    localparam logic [3:0] CTRL_ADDR = 4'hF;

    localparam int B_UIE  = 5;
    localparam int B_TIE  = 4;
    localparam int B_AIE  = 3;
    localparam int B_UNIT = 0;

    localparam int B_UF = 5;
    localparam int B_TF = 4;
    localparam int B_AF = 3;
    localparam int B_LV = 1;

    localparam int N_AUTO = 2;   // sources with self-release: update, timer

    typedef struct packed {
        logic [1:0] comp;
        logic       uie;
        logic       tie;
        logic       aie;
        logic       unit;
        logic       uf;
        logic       tf;
        logic       af;
        logic       lv;
    } tu_state_t;
endpackage

// File: rtl/tu_evt_sel.sv
module tu_evt_sel (
    input  logic sec_tick,
    input  logic min_tick,
    input  logic unit_min,
    output logic upd_evt
);
    always_comb begin
        upd_evt = unit_min ? min_tick : sec_tick;
    end
endmodule

// File: rtl/tu_release.sv
module tu_release #(
    parameter int HOLD_CYCLES = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic cancel,
    output logic active
);
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

    typedef struct packed {
        logic             act;
        logic [CNT_W-1:0] cnt;
    } rel_t;

    rel_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (fire) begin
            r_d.act = 1'b1;
            r_d.cnt = CNT_W'(HOLD_CYCLES - 1);
        end else if (cancel) begin
            r_d.act = 1'b0;
            r_d.cnt = '0;
        end else if (r_q.act) begin
            if (r_q.cnt == '0) begin
                r_d.act = 1'b0;
            end else begin
                r_d.cnt = r_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign active = r_q.act;
endmodule

// File: rtl/tu_irq_ctrl.sv
module tu_irq_ctrl #(
    parameter int ADDR_W      = 4,
    parameter int HOLD_CYCLES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              min_tick,
    input  logic              timer_evt,
    input  logic              alarm_evt,
    input  logic              lowv_det,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              int_oe
);
    import tu_pkg::*;

    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(FLAG_ADDR);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);

    tu_state_t st_q, st_d;

    logic              upd_evt;
    logic              flag_wr, ctrl_wr;
    logic [N_AUTO-1:0] fire, cancel, auto_act;
    logic              alm_req;
    logic              unused_wbits;

    assign unused_wbits = ^reg_wdata[2:1];

    tu_evt_sel i_sel (
        .sec_tick (sec_tick),
        .min_tick (min_tick),
        .unit_min (st_q.unit),
        .upd_evt  (upd_evt)
    );

    always_comb begin
        flag_wr = reg_we && (reg_addr == A_FLAG);
        ctrl_wr = reg_we && (reg_addr == A_CTRL);

        st_d = st_q;
        if (ctrl_wr) begin
            st_d.comp = reg_wdata[7:6];
            st_d.uie  = reg_wdata[B_UIE];
            st_d.tie  = reg_wdata[B_TIE];
            st_d.aie  = reg_wdata[B_AIE];
            st_d.unit = reg_wdata[B_UNIT];
        end
        // write-0-to-clear; an event in the same cycle wins
        if (flag_wr) begin
            st_d.uf = st_q.uf & reg_wdata[B_UF];
            st_d.tf = st_q.tf & reg_wdata[B_TF];
            st_d.af = st_q.af & reg_wdata[B_AF];
            st_d.lv = st_q.lv & reg_wdata[B_LV];
        end
        if (upd_evt)   st_d.uf = 1'b1;
        if (timer_evt) st_d.tf = 1'b1;
        if (alarm_evt) st_d.af = 1'b1;
        if (lowv_det)  st_d.lv = 1'b1;

        fire[0]   = upd_evt & st_d.uie;
        fire[1]   = timer_evt & st_d.tie;
        cancel[0] = ctrl_wr & ~reg_wdata[B_UIE];
        cancel[1] = ctrl_wr & ~reg_wdata[B_TIE];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.lv <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar g = 0; g < N_AUTO; g++) begin : g_auto
            tu_release #(.HOLD_CYCLES(HOLD_CYCLES)) i_rel (
                .clk    (clk),
                .rst_n  (rst_n),
                .fire   (fire[g]),
                .cancel (cancel[g]),
                .active (auto_act[g])
            );
        end
    endgenerate

    assign alm_req = st_q.af & st_q.aie;
    assign int_oe  = (|auto_act) | alm_req;

    always_comb begin
        reg_rdata = 8'h00;
        if (reg_addr == A_FLAG) begin
            reg_rdata[B_UF] = st_q.uf;
            reg_rdata[B_TF] = st_q.tf;
            reg_rdata[B_AF] = st_q.af;
            reg_rdata[B_LV] = st_q.lv;
        end else if (reg_addr == A_CTRL) begin
            reg_rdata[7:6]    = st_q.comp;
            reg_rdata[B_UIE]  = st_q.uie;
            reg_rdata[B_TIE]  = st_q.tie;
            reg_rdata[B_AIE]  = st_q.aie;
            reg_rdata[B_UNIT] = st_q.unit;
        end
    end
endmodule

// File: rtl/tu_irq_ctrl_chk.sv
module tu_irq_ctrl_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sec_tick,
    input logic              min_tick,
    input logic              timer_evt,
    input logic              alarm_evt,
    input logic              lowv_det,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [7:0]        reg_wdata,
    input logic              int_oe,
    input tu_pkg::tu_state_t st_q
);
    import tu_pkg::*;

    logic any_evt;
    assign any_evt = sec_tick | min_tick | timer_evt | alarm_evt | lowv_det;

    // R2: second strobe in second mode sets the update flag
    p_sec_sets_uf_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !st_q.unit) |=> st_q.uf);

    // R9: a timer event always leaves the timer flag set, even against a clear
    p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        timer_evt |=> st_q.tf);

    // R7: a pending enabled alarm keeps the line asserted
    p_alarm_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.af && st_q.aie) |-> int_oe);

    // R5: clearing all enables with no event releases the line next cycle
    p_enable_cancel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(CTRL_ADDR)
         && reg_wdata[B_UIE] == 1'b0 && reg_wdata[B_TIE] == 1'b0
         && reg_wdata[B_AIE] == 1'b0 && !any_evt) |=> !int_oe);

    // R8: writing all ones to the flag register changes no flag
    p_write_one_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(FLAG_ADDR) && reg_wdata == 8'hFF && !any_evt)
        |=> (st_q.uf == $past(st_q.uf) && st_q.tf == $past(st_q.tf)
             && st_q.af == $past(st_q.af) && st_q.lv == $past(st_q.lv)));
endmodule

bind tu_irq_ctrl tu_irq_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_tick  (sec_tick),
    .min_tick  (min_tick),
    .timer_evt (timer_evt),
    .alarm_evt (alarm_evt),
    .lowv_det  (lowv_det),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .int_oe    (int_oe),
    .st_q      (st_q)
);

// File: tb/test_tu_irq_ctrl.sv
module test_tu_irq_ctrl;
    localparam int ADDR_W = 4;
    localparam int HOLD   = 256;
    localparam logic [3:0] AF_ = 4'hE;
    localparam logic [3:0] AC_ = 4'hF;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sec_tick = 1'b0, min_tick = 1'b0;
    logic              timer_evt = 1'b0, alarm_evt = 1'b0, lowv_det = 1'b0;
    logic              reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [7:0]        reg_wdata = '0;
    logic [7:0]        reg_rdata;
    logic              int_oe;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    tu_irq_ctrl #(.ADDR_W(ADDR_W), .HOLD_CYCLES(HOLD)) i_tu_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .min_tick(min_tick),
        .timer_evt(timer_evt), .alarm_evt(alarm_evt), .lowv_det(lowv_det),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .int_oe(int_oe)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // all drive tasks start and end at a falling edge
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic strobe(input int which);
        case (which)
            0: sec_tick = 1'b1;
            1: min_tick = 1'b1;
            2: timer_evt = 1'b1;
            default: alarm_evt = 1'b1;
        endcase
        @(negedge clk);
        sec_tick = 1'b0; min_tick = 1'b0; timer_evt = 1'b0; alarm_evt = 1'b0;
    endtask

    task automatic count_oe(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            if (int_oe) c++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd(AF_, d); check("R1 flags", d, 8'h02);
        rd(AC_, d); check("R1 ctrl", d, 8'h00);
        check("R1 int_oe", int_oe, 0);
    endtask

    task automatic t_lv_flag;
        logic [7:0] d;
        wr(AF_, 8'hFF); rd(AF_, d); check("R8 write one keeps", d, 8'h02);
        wr(AF_, 8'h00); rd(AF_, d); check("R8 write zero clears lv", d, 8'h00);
    endtask

    task automatic t_unit;
        logic [7:0] d;
        wr(AC_, 8'h00);
        strobe(1); rd(AF_, d); check("R2 min ignored in sec mode", d, 8'h00);
        strobe(0); rd(AF_, d); check("R2 sec sets uf", d, 8'h20);
        wr(AF_, 8'h00);
        wr(AC_, 8'h01);
        strobe(0); rd(AF_, d); check("R2 sec ignored in min mode", d, 8'h00);
        strobe(1); rd(AF_, d); check("R2 min sets uf", d, 8'h20);
        wr(AF_, 8'h00); wr(AC_, 8'h00);
    endtask

    task automatic t_masked;
        logic [7:0] d; int c;
        wr(AC_, 8'h00);
        strobe(0); count_oe(HOLD + 20, c);
        check("R4 masked update no int", c, 0);
        rd(AF_, d); check("R4 masked update flag", d, 8'h20);
        wr(AF_, 8'h00);
    endtask

    task automatic t_pulse;
        logic [7:0] d; int c;
        wr(AC_, 8'h20);
        strobe(0); count_oe(HOLD + 20, c);
        check("R3 hold length", c, HOLD);
        check("R3 released", int_oe, 0);
        rd(AF_, d); check("R3 uf kept", d, 8'h20);
        wr(AF_, 8'h00);
    endtask

    task automatic t_retrig;
        int c;
        strobe(0);
        repeat (100) @(negedge clk);
        check("R11 still active", int_oe, 1);
        strobe(0); count_oe(HOLD + 20, c);
        check("R11 restarted window", c, HOLD);
        wr(AF_, 8'h00);
    endtask

    task automatic t_cancel;
        logic [7:0] d;
        strobe(0);
        repeat (5) @(negedge clk);
        check("R5 active before cancel", int_oe, 1);
        wr(AC_, 8'h00);
        check("R5 cancelled", int_oe, 0);
        rd(AF_, d); check("R5 uf kept", d, 8'h20);
        wr(AF_, 8'h00);
    endtask

    task automatic t_timer;
        logic [7:0] d; int c;
        wr(AC_, 8'h10);
        strobe(2); count_oe(HOLD + 20, c);
        check("R6 timer hold length", c, HOLD);
        rd(AF_, d); check("R6 tf set", d, 8'h10);
        strobe(2);
        repeat (3) @(negedge clk);
        wr(AC_, 8'h00);
        check("R6 timer cancel", int_oe, 0);
        wr(AF_, 8'h00);
    endtask

    task automatic t_alarm;
        logic [7:0] d;
        wr(AC_, 8'h08);
        strobe(3);
        repeat (HOLD + 100) @(negedge clk);
        check("R7 alarm held", int_oe, 1);
        wr(AF_, 8'hFF);
        check("R8 alarm flag write one", int_oe, 1);
        wr(AF_, 8'h00);
        check("R7 release on flag clear", int_oe, 0);
        strobe(3);
        check("R7 alarm again", int_oe, 1);
        wr(AC_, 8'h00);
        check("R7 release on enable clear", int_oe, 0);
        rd(AF_, d); check("R7 af kept", d, 8'h08);
        wr(AF_, 8'h00);
    endtask

    task automatic t_race;
        logic [7:0] d;
        wr(AC_, 8'h00);
        strobe(0); strobe(2);
        sec_tick = 1'b1; timer_evt = 1'b1;
        wr(AF_, 8'h00);
        sec_tick = 1'b0; timer_evt = 1'b0;
        rd(AF_, d); check("R9 event beats clear", d, 8'h30);
        wr(AF_, 8'h00);
        rd(AF_, d); check("R9 clear afterwards", d, 8'h00);
    endtask

    task automatic t_ctrl_rb;
        logic [7:0] d;
        wr(AC_, 8'hFF); rd(AC_, d); check("R10 ctrl readback", d, 8'hF9);
        wr(AC_, 8'h40); rd(AC_, d); check("R10 ctrl comp bits", d, 8'h40);
        wr(AF_, 8'h00); rd(AC_, d); check("R10 flag write leaves ctrl", d, 8'h40);
        rd(4'h3, d); check("R10 other address", d, 8'h00);
        wr(AC_, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lv_flag();
        t_unit();
        t_masked();
        t_pulse();
        t_retrig();
        t_cancel();
        t_timer();
        t_alarm();
        t_race();
        t_ctrl_rb();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule